// File: doc/BRIEF.md
# Daisy-Chain Interrupt Arbiter

The block gathers interrupt requests from a row of device interfaces. It raises a single interrupt line to the processor while any of them is waiting. Each device keeps a sticky pending flag. A request pulse on its input sets the flag at the next clock edge.

When the processor answers with an acknowledge, the acknowledge ripples through the stages in index order, starting at stage 0, which sits closest to the processor. A stage that is not pending forwards the acknowledge unchanged. The first pending stage stops it and claims the cycle. The claiming stage drives its own constant vector onto the vector output while the valid flag is high, and its pending flag clears at the end of that cycle. Every other pending device waits for a later acknowledge. Priority therefore depends only on position.

The acknowledge chain acts on the registered pending flags. A request that arrives in the same cycle as an acknowledge is recorded, but it competes only from the next acknowledge on.

Top module: `irq_daisy_chain`

## Requirements
- R1: While rst_ni is low and after its release, with no request seen, irq_o is 0, vec_valid_o is 0 and vec_o is 0.
- R2: A 1 on req_i[i] at a clock edge sets that device's pending flag. irq_o is high in every cycle that at least one device is pending and low otherwise.
- R3: In a cycle with ack_i high and some device pending, the pending device with the lowest index wins, and vec_o equals vec_i[i*VEC_W +: VEC_W] of that device within the same cycle.
- R4: vec_valid_o is high exactly in the cycles where ack_i is high and at least one device is pending.
- R5: The winning device's pending flag is clear after the acknowledge cycle. Other pending devices stay pending and are served by later acknowledges in ascending index order.
- R6: A stage that is not pending forwards the acknowledge, and a pending stage blocks it, so each acknowledge cycle serves at most one device.
- R7: A request that arrives in an acknowledge cycle does not take part in that acknowledge. It is pending afterwards, even when it is for the device that won that cycle.
- R8: vec_o is all zeros whenever vec_valid_o is low, including an acknowledge while nothing is pending.
- R9: Without ack_i, pending flags never clear, and repeated requests to a device that is already pending change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_DEV | Per-device interrupt request, bit i = device i |
| vec_i | input | NUM_DEV*VEC_W | Per-device vector constants, device i at bits i*VEC_W +: VEC_W |
| ack_i | input | 1 | Interrupt acknowledge from the processor, one device served per high cycle |
| irq_o | output | 1 | Combined interrupt request |
| vec_o | output | VEC_W | Vector of the claiming device, zero otherwise |
| vec_valid_o | output | 1 | High in a cycle where a device claimed the acknowledge |

## Verification
A request affects irq_o one edge later, because it passes through the pending flag. The acknowledge result on vec_o and vec_valid_o appears in the same cycle as ack_i. The clearing of the winner appears at the next edge. The bench drives inputs at the falling edge and compares the outputs a moment later, against a model whose pending state advances only once per cycle. In that way same-cycle and next-cycle effects are each checked in the cycle they are due. Directed sequences cover back-to-back acknowledges, requests that collide with an acknowledge, and idle acknowledges, and a long pseudo-random run follows them.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

  typedef struct packed {
    logic ack_out;
    logic claim;
    logic pend;
  } stage_out_t;

endpackage

// File: rtl/irq_chain_stage.sv
module irq_chain_stage
  import irq_chain_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       ack_in_i,
  output stage_out_t st_o
);

  logic pend_q;
  logic claim;

  assign claim = ack_in_i & pend_q;

  // new request wins over the clear so a collision stays pending
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= (pend_q & ~claim) | req_i;
  end

  assign st_o.ack_out = ack_in_i & ~pend_q;
  assign st_o.claim   = claim;
  assign st_o.pend    = pend_q;

endmodule

// File: rtl/irq_vec_mux.sv
module irq_vec_mux #(
  parameter int unsigned NUM_DEV = 8,
  parameter int unsigned VEC_W   = 8
) (
  input  logic [NUM_DEV-1:0]       claim_i,
  input  logic [NUM_DEV*VEC_W-1:0] vec_i,
  output logic [VEC_W-1:0]         vec_o,
  output logic                     valid_o
);

  // claim_i is one-hot or zero, so an AND-OR tree is enough
  always_comb begin
    vec_o = '0;
    for (int i = 0; i < NUM_DEV; i++) begin
      vec_o = vec_o | (vec_i[i*VEC_W +: VEC_W] & {VEC_W{claim_i[i]}});
    end
  end

  assign valid_o = |claim_i;

endmodule

// File: rtl/irq_daisy_chain.sv
module irq_daisy_chain
  import irq_chain_pkg::*;
#(
  parameter int unsigned NUM_DEV = 8,
  parameter int unsigned VEC_W   = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_DEV-1:0]       req_i,
  input  logic [NUM_DEV*VEC_W-1:0] vec_i,
  input  logic                     ack_i,
  output logic                     irq_o,
  output logic [VEC_W-1:0]         vec_o,
  output logic                     vec_valid_o
);

  localparam int unsigned CHAIN_LEN = NUM_DEV + 1;

  logic [CHAIN_LEN-1:0] ack_chain;
  logic [NUM_DEV-1:0]   claim;
  logic [NUM_DEV-1:0]   pend;

  assign ack_chain[0] = ack_i;

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_stage
    stage_out_t st;

    irq_chain_stage i_stage (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .req_i    (req_i[g]),
      .ack_in_i (ack_chain[g]),
      .st_o     (st)
    );

    assign ack_chain[g+1] = st.ack_out;
    assign claim[g]       = st.claim;
    assign pend[g]        = st.pend;
  end

  assign irq_o = |pend;

  irq_vec_mux #(
    .NUM_DEV (NUM_DEV),
    .VEC_W   (VEC_W)
  ) i_mux (
    .claim_i (claim),
    .vec_i   (vec_i),
    .vec_o   (vec_o),
    .valid_o (vec_valid_o)
  );

endmodule

// File: rtl/irq_daisy_chain_chk.sv
module irq_daisy_chain_chk #(
  parameter int unsigned NUM_DEV = 8,
  parameter int unsigned VEC_W   = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_DEV-1:0] req_i,
  input logic               ack_i,
  input logic               irq_o,
  input logic [VEC_W-1:0]   vec_o,
  input logic               vec_valid_o,
  input logic [NUM_DEV-1:0] pend,
  input logic [NUM_DEV-1:0] claim
);

  AST_REQ_RAISES_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |=> irq_o); // R2

  AST_ACK_SERVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |-> vec_valid_o); // R3

  AST_VALID_NEEDS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> (ack_i && irq_o)); // R4

  AST_SINGLE_CLAIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(claim)); // R6

  AST_IDLE_VEC_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_valid_o |-> (vec_o == '0)); // R8

  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> ((pend & $past(pend)) == $past(pend))); // R9

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    AST_WINNER_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (claim[g] && !req_i[g]) |=> !pend[g]); // R5

    AST_LOSER_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend[g] && !claim[g]) |=> pend[g]); // R5

    AST_LATE_REQ_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i && req_i[g]) |=> pend[g]); // R7
  end

endmodule

bind irq_daisy_chain irq_daisy_chain_chk #(
  .NUM_DEV (NUM_DEV),
  .VEC_W   (VEC_W)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .ack_i       (ack_i),
  .irq_o       (irq_o),
  .vec_o       (vec_o),
  .vec_valid_o (vec_valid_o),
  .pend        (pend),
  .claim       (claim)
);

// File: tb/test_irq_daisy_chain.sv
`timescale 1ns/1ps
module test_irq_daisy_chain;

  localparam int N = 8;
  localparam int W = 8;

  logic           clk_i = 1'b0;
  logic           rst_ni;
  logic [N-1:0]   req_i;
  logic [N*W-1:0] vec_i;
  logic           ack_i;
  logic           irq_o;
  logic [W-1:0]   vec_o;
  logic           vec_valid_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [N-1:0] model;

  always #2.5 clk_i = ~clk_i;

  irq_daisy_chain #(.NUM_DEV(N), .VEC_W(W)) i_irq_daisy_chain (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .vec_i       (vec_i),
    .ack_i       (ack_i),
    .irq_o       (irq_o),
    .vec_o       (vec_o),
    .vec_valid_o (vec_valid_o)
  );

  function automatic logic [W-1:0] vec_of(int i);
    return W'(8'h41 + i * 7);
  endfunction

  task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // drive one cycle, compare against the model, then advance the model
  task automatic step(logic [N-1:0] req, logic ack, string tag);
    logic         e_irq;
    logic         e_val;
    logic [W-1:0] e_vec;
    logic [N-1:0] win;
    @(negedge clk_i);
    req_i = req;
    ack_i = ack;
    #1;
    e_irq = (model != '0);
    e_val = 1'b0;
    e_vec = '0;
    win   = '0;
    if (ack) begin
      for (int i = 0; i < N; i++) begin
        if (model[i] && !e_val) begin
          e_val  = 1'b1;
          e_vec  = vec_of(i);
          win[i] = 1'b1;
        end
      end
    end
    chk(tag, "irq_o (R2)", W'(irq_o), W'(e_irq));
    chk(tag, "vec_valid_o (R4)", W'(vec_valid_o), W'(e_val));
    chk(tag, e_val ? "vec_o (R3)" : "vec_o (R8)", vec_o, e_vec);
    model = (model & ~win) | req;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < N; i++) vec_i[i*W +: W] = vec_of(i);
    rst_ni = 1'b0;
    req_i  = '0;
    ack_i  = 1'b0;
    model  = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk("R1", "irq_o in reset", W'(irq_o), '0);
    chk("R1", "vec_valid_o in reset", W'(vec_valid_o), '0);
    chk("R1", "vec_o in reset", vec_o, '0);
    rst_ni = 1'b1;
    step('0, 1'b0, "R1");
    step('0, 1'b1, "R1");

    // single request, then serve it
    step(8'h20, 1'b0, "R2");
    step('0, 1'b0, "R2");
    step('0, 1'b1, "R3");
    step('0, 1'b0, "R5");
    // acknowledge with nothing pending
    step('0, 1'b1, "R8");

    // several pending, served in index order
    step(8'hA6, 1'b0, "R5");
    for (int k = 0; k < 5; k++) step('0, 1'b1, "R5");
    step('0, 1'b0, "R5");

    // request to a higher-priority device in the acknowledge cycle
    step(8'h08, 1'b0, "R7");
    step(8'h01, 1'b1, "R7");
    step('0, 1'b1, "R7");
    // request to the winner in its own acknowledge cycle
    step(8'h10, 1'b0, "R7");
    step(8'h10, 1'b1, "R7");
    step('0, 1'b1, "R7");
    step('0, 1'b1, "R7");

    // no acknowledge: flags hold, repeats ignored
    step(8'h84, 1'b0, "R9");
    for (int k = 0; k < 6; k++) step(8'h84, 1'b0, "R9");
    step('0, 1'b1, "R6");
    step('0, 1'b1, "R6");
    step('0, 1'b1, "R6");

    // pseudo-random traffic
    lfsr = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] rq;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rq   = (lfsr[3:1] == 3'd0) ? N'(lfsr[15:8]) : '0;
      step(rq, lfsr[0] & lfsr[5], "R6");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule